// File: doc/BRIEF.md
# Virtio Common Configuration Register Bank

This block is the register file that a paravirtual device presents to its driver for the device-wide and per-queue parts of the common configuration structure. A driver reads the device's 64-bit feature set and writes back its accepted features through 32-bit windows chosen by select registers. It also sets the configuration interrupt vector and the device status byte, and sets up each virtqueue's size, vector, enable flag and three 64-bit ring addresses. A queue-select register picks which queue's fields are visible at the per-queue offsets.

Accesses arrive on a dword-wide memory-mapped port with byte enables. The byte offset of every field follows the common layout. Every multi-byte field is little-endian, so a 16-bit field at offset 0x12 occupies data lanes 31:16 of the dword at 0x10, and a 64-bit ring address is split into a low dword and a high dword. The current size and enable of every queue are driven out in parallel so that the queue engines can use them.

Top module: `vq_common_cfg`

## Requirements
- R1: After rst every field reads its reset value: feature selects, driver features, status, queue select, queue enables and ring addresses read 0, both interrupt vectors read 0xFFFF, and each queue size reads that queue's maximum from QMAX_TABLE (16 bits per queue, queue 0 in the lowest bits).
- R2: The device feature dword at 0x04 returns feature bits 31:0 when the device select at 0x00 is 0 and bits 63:32 when it is 1. It returns 0 for any other select value. Bit 32 always reads 1, and bits 63:33 come from DEV_FEAT_HI_EXTRA.
- R3: The driver feature dword at 0x0C writes and reads bits 31:0 when the driver select at 0x08 is 0, and bits 63:32 when it is 1. For any other select value, writes are dropped and reads return 0.
- R4: num_queues (0x12, lanes 31:16) reads NUM_Q, and queue_notify_off (0x1E, lanes 31:16) reads the selected queue index. Writes to these fields and to the device feature dword have no effect.
- R5: queue_size (0x18), queue vector (0x1A), queue_enable (0x1C, bit 0) and the ring addresses (desc 0x20/0x24, avail 0x28/0x2C, used 0x30/0x34, low dword first) access only the bank whose index was last written to queue_select (0x16, lanes 31:16).
- R6: While queue_select is NUM_Q or greater, every per-queue field reads 0 and writes to them change no bank.
- R7: A queue_size write is kept only if the value is 0, or is a power of two that does not exceed that queue's maximum. Any other value leaves the previous size in place.
- R8: Output q_enable[i] and output slice q_size[16*i+15:16*i] always equal queue i's stored enable and size.
- R9: Only natural-width accesses reach a field. A 32-bit field needs be=4'hF, a 16-bit field in lanes 15:0 needs be=4'h3, one in lanes 31:16 needs be=4'hC, and status needs be=4'h1 at 0x14. Writes with any other enable pattern, writes to the unused byte 0x15 and writes to a misaligned address are dropped. Reads of these forms return 0.
- R10: Writing 0 to device_status returns every field listed in R1 to its reset value at that clock edge.
- R11: rd_data carries the value selected by a read one cycle after rd_en is high, and it is 0 in any cycle that follows a cycle with rd_en low.
- R12: Dword offsets 0x38 and 0x3C read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the current cycle |
| rd_en | input | 1 | Read strobe for the current cycle |
| addr | input | 6 | Byte address, dword aligned |
| be | input | 4 | Byte enables, bit i covers data bits 8i+7:8i |
| wdata | input | 32 | Write data |
| rd_data | output | 32 | Registered read data |
| q_enable | output | NUM_Q | Enable flag of each queue |
| q_size | output | 16*NUM_Q | Size of each queue, queue 0 in the low bits |

## Verification
A write takes effect at the clock edge where wr_en is sampled. The bench raises wr_en at a falling edge and lowers it at the next falling edge, so the parallel q_size and q_enable outputs are compared at that falling edge, after exactly one register stage. Read data passes through one output register. The bench holds rd_en for one cycle and samples rd_data at the falling edge after the capturing edge, then samples again a cycle later to confirm the return to zero. A soft reset through a zero status write has the same one-edge timing, so every field is checked immediately after that single write.

// File: rtl/vq_cfg_pkg.sv
package vq_cfg_pkg;

    typedef enum logic [3:0] {
        DW_DEV_SEL   = 4'd0,
        DW_DEV_FEAT  = 4'd1,
        DW_DRV_SEL   = 4'd2,
        DW_DRV_FEAT  = 4'd3,
        DW_VEC_COUNT = 4'd4,
        DW_STAT_QSEL = 4'd5,
        DW_SIZE_VEC  = 4'd6,
        DW_EN_NOTIFY = 4'd7,
        DW_DESC_LO   = 4'd8,
        DW_DESC_HI   = 4'd9,
        DW_AVAIL_LO  = 4'd10,
        DW_AVAIL_HI  = 4'd11,
        DW_USED_LO   = 4'd12,
        DW_USED_HI   = 4'd13,
        DW_SPARE0    = 4'd14,
        DW_SPARE1    = 4'd15
    } dword_e;

    localparam logic [3:0] BE_WORD  = 4'hF;
    localparam logic [3:0] BE_HALF0 = 4'h3;
    localparam logic [3:0] BE_HALF1 = 4'hC;
    localparam logic [3:0] BE_BYTE0 = 4'h1;

    localparam logic [15:0] NO_VECTOR = 16'hFFFF;
    localparam int RING_HALVES = 6;

    typedef struct packed {
        logic [15:0] size;
        logic [15:0] vec;
        logic        en;
        logic [63:0] desc;
        logic [63:0] avail;
        logic [63:0] used;
    } qbank_t;

    function automatic logic size_ok(input logic [15:0] v, input logic [15:0] lim);
        return (v == 16'd0) || (((v & (v - 16'd1)) == 16'd0) && (v <= lim));
    endfunction

endpackage

// File: rtl/vq_feature_window.sv
module vq_feature_window
    import vq_cfg_pkg::*;
#(
    parameter logic [31:0] DEV_LO       = 32'h0000_0021,
    parameter logic [30:0] DEV_HI_EXTRA = 31'h0000_0004
) (
    input  logic        clk,
    input  logic        clr,
    input  logic        we_dsel,
    input  logic        we_gsel,
    input  logic        we_gfeat,
    input  logic [31:0] wdata,
    output logic [31:0] dsel_q,
    output logic [31:0] gsel_q,
    output logic [31:0] dev_word,
    output logic [31:0] drv_word
);
    localparam logic [63:0] DEV_FULL = {DEV_HI_EXTRA, 1'b1, DEV_LO};

    logic [63:0] drv_feat;

    always_ff @(posedge clk) begin
        if (clr) begin
            dsel_q   <= '0;
            gsel_q   <= '0;
            drv_feat <= '0;
        end else begin
            if (we_dsel) dsel_q <= wdata;
            if (we_gsel) gsel_q <= wdata;
            if (we_gfeat) begin
                if (gsel_q == 32'd0)      drv_feat[31:0]  <= wdata;
                else if (gsel_q == 32'd1) drv_feat[63:32] <= wdata;
            end
        end
    end

    always_comb begin
        dev_word = '0;
        drv_word = '0;
        if (dsel_q == 32'd0)      dev_word = DEV_FULL[31:0];
        else if (dsel_q == 32'd1) dev_word = DEV_FULL[63:32];
        if (gsel_q == 32'd0)      drv_word = drv_feat[31:0];
        else if (gsel_q == 32'd1) drv_word = drv_feat[63:32];
    end

    // R3: a driver feature write under an out-of-range select leaves the word alone
    assert_drv_drop_R3: assert property (@(posedge clk) disable iff (clr)
        (we_gfeat && gsel_q > 32'd1) |=> $stable(drv_feat));

endmodule

// File: rtl/vq_queue_slot.sv
module vq_queue_slot
    import vq_cfg_pkg::*;
#(
    parameter logic [15:0] MAX_SIZE = 16'd256
) (
    input  logic                   clk,
    input  logic                   clr,
    input  logic                   pick,
    input  logic                   we_size,
    input  logic                   we_vec,
    input  logic                   we_en,
    input  logic [RING_HALVES-1:0] we_ring,
    input  logic [31:0]            wdata,
    output qbank_t                 bank
);
    always_ff @(posedge clk) begin
        if (clr) begin
            bank.size  <= MAX_SIZE;
            bank.vec   <= NO_VECTOR;
            bank.en    <= 1'b0;
            bank.desc  <= '0;
            bank.avail <= '0;
            bank.used  <= '0;
        end else if (pick) begin
            if (we_size && size_ok(wdata[15:0], MAX_SIZE)) bank.size <= wdata[15:0];
            if (we_vec)     bank.vec          <= wdata[31:16];
            if (we_en)      bank.en           <= wdata[0];
            if (we_ring[0]) bank.desc[31:0]   <= wdata;
            if (we_ring[1]) bank.desc[63:32]  <= wdata;
            if (we_ring[2]) bank.avail[31:0]  <= wdata;
            if (we_ring[3]) bank.avail[63:32] <= wdata;
            if (we_ring[4]) bank.used[31:0]   <= wdata;
            if (we_ring[5]) bank.used[63:32]  <= wdata;
        end
    end

    // R7: the stored size is always zero or a power of two within the limit
    assert_size_legal_R7: assert property (@(posedge clk) disable iff (clr)
        (bank.size == 16'd0) || ($countones(bank.size) == 1 && bank.size <= MAX_SIZE));

    // R5: a bank that is not selected keeps every field
    assert_unpicked_hold_R5: assert property (@(posedge clk) disable iff (clr)
        (!pick) |=> $stable(bank));

endmodule

// File: rtl/vq_common_cfg.sv
module vq_common_cfg
    import vq_cfg_pkg::*;
#(
    parameter int                  NUM_Q             = 4,
    parameter logic [NUM_Q*16-1:0] QMAX_TABLE        = 64'h0020_0040_0080_0100,
    parameter logic [31:0]         DEV_FEAT_LO       = 32'h0000_0021,
    parameter logic [30:0]         DEV_FEAT_HI_EXTRA = 31'h0000_0004
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic                rd_en,
    input  logic [5:0]          addr,
    input  logic [3:0]          be,
    input  logic [31:0]         wdata,
    output logic [31:0]         rd_data,
    output logic [NUM_Q-1:0]    q_enable,
    output logic [NUM_Q*16-1:0] q_size
);
    localparam logic [15:0] QCOUNT = 16'(NUM_Q);

    dword_e dw;
    logic   aligned, wr, q_ok;
    logic   be_word, be_half0, be_half1, be_byte0;
    logic   we_dsel, we_gsel, we_gfeat, we_msix, we_stat, we_qsel;
    logic   we_qsize, we_qvec, we_qen, clr;
    logic [RING_HALVES-1:0] we_ring;

    logic [15:0] msix_q;
    logic [7:0]  status_q;
    logic [15:0] qsel_q;
    logic [31:0] dsel_q, gsel_q, dev_word, drv_word;
    logic [31:0] rd_next;

    qbank_t banks [NUM_Q];
    qbank_t cur;

    assign dw       = dword_e'(addr[5:2]);
    assign aligned  = (addr[1:0] == 2'b00);
    assign wr       = wr_en && aligned;
    assign be_word  = (be == BE_WORD);
    assign be_half0 = (be == BE_HALF0);
    assign be_half1 = (be == BE_HALF1);
    assign be_byte0 = (be == BE_BYTE0);
    assign q_ok     = (qsel_q < QCOUNT);

    assign we_dsel  = wr && be_word  && dw == DW_DEV_SEL;
    assign we_gsel  = wr && be_word  && dw == DW_DRV_SEL;
    assign we_gfeat = wr && be_word  && dw == DW_DRV_FEAT;
    assign we_msix  = wr && be_half0 && dw == DW_VEC_COUNT;
    assign we_stat  = wr && be_byte0 && dw == DW_STAT_QSEL;
    assign we_qsel  = wr && be_half1 && dw == DW_STAT_QSEL;
    assign we_qsize = wr && be_half0 && dw == DW_SIZE_VEC && q_ok;
    assign we_qvec  = wr && be_half1 && dw == DW_SIZE_VEC && q_ok;
    assign we_qen   = wr && be_half0 && dw == DW_EN_NOTIFY && q_ok;
    assign clr      = rst || (we_stat && wdata[7:0] == 8'd0);

    for (genvar h = 0; h < RING_HALVES; h++) begin : g_ring_we
        assign we_ring[h] = wr && be_word && q_ok && (addr[5:2] == 4'(8 + h));
    end

    always_ff @(posedge clk) begin
        if (clr) begin
            msix_q   <= NO_VECTOR;
            status_q <= '0;
            qsel_q   <= '0;
        end else begin
            if (we_msix) msix_q   <= wdata[15:0];
            if (we_stat) status_q <= wdata[7:0];
            if (we_qsel) qsel_q   <= wdata[31:16];
        end
    end

    vq_feature_window #(
        .DEV_LO       (DEV_FEAT_LO),
        .DEV_HI_EXTRA (DEV_FEAT_HI_EXTRA)
    ) u_feat (
        .clk      (clk),
        .clr      (clr),
        .we_dsel  (we_dsel),
        .we_gsel  (we_gsel),
        .we_gfeat (we_gfeat),
        .wdata    (wdata),
        .dsel_q   (dsel_q),
        .gsel_q   (gsel_q),
        .dev_word (dev_word),
        .drv_word (drv_word)
    );

    for (genvar g = 0; g < NUM_Q; g++) begin : g_slot
        vq_queue_slot #(
            .MAX_SIZE (QMAX_TABLE[g*16 +: 16])
        ) u_slot (
            .clk      (clk),
            .clr      (clr),
            .pick     (qsel_q == 16'(g)),
            .we_size  (we_qsize),
            .we_vec   (we_qvec),
            .we_en    (we_qen),
            .we_ring  (we_ring),
            .wdata    (wdata),
            .bank     (banks[g])
        );
        assign q_enable[g]         = banks[g].en;
        assign q_size[g*16 +: 16]  = banks[g].size;
    end

    always_comb begin
        cur = '0;
        for (int q = 0; q < NUM_Q; q++) begin
            if (qsel_q == 16'(q)) cur = banks[q];
        end
    end

    always_comb begin
        rd_next = '0;
        unique case (dw)
            DW_DEV_SEL:   if (be_word) rd_next = dsel_q;
            DW_DEV_FEAT:  if (be_word) rd_next = dev_word;
            DW_DRV_SEL:   if (be_word) rd_next = gsel_q;
            DW_DRV_FEAT:  if (be_word) rd_next = drv_word;
            DW_VEC_COUNT: begin
                if (be_half0)      rd_next = {16'h0, msix_q};
                else if (be_half1) rd_next = {QCOUNT, 16'h0};
            end
            DW_STAT_QSEL: begin
                if (be_byte0)      rd_next = {24'h0, status_q};
                else if (be_half1) rd_next = {qsel_q, 16'h0};
            end
            DW_SIZE_VEC: begin
                if (be_half0)      rd_next = {16'h0, cur.size};
                else if (be_half1) rd_next = {cur.vec, 16'h0};
            end
            DW_EN_NOTIFY: begin
                if (be_half0)              rd_next = {31'h0, cur.en};
                else if (be_half1 && q_ok) rd_next = {qsel_q, 16'h0};
            end
            DW_DESC_LO:   if (be_word) rd_next = cur.desc[31:0];
            DW_DESC_HI:   if (be_word) rd_next = cur.desc[63:32];
            DW_AVAIL_LO:  if (be_word) rd_next = cur.avail[31:0];
            DW_AVAIL_HI:  if (be_word) rd_next = cur.avail[63:32];
            DW_USED_LO:   if (be_word) rd_next = cur.used[31:0];
            DW_USED_HI:   if (be_word) rd_next = cur.used[63:32];
            default:      rd_next = '0;
        endcase
        if (!aligned) rd_next = '0;
    end

    always_ff @(posedge clk) begin
        if (rst)        rd_data <= '0;
        else if (rd_en) rd_data <= rd_next;
        else            rd_data <= '0;
    end

    // R11: no read strobe, zero data on the next cycle
    assert_rd_idle_R11: assert property (@(posedge clk) disable iff (rst)
        (!rd_en) |=> (rd_data == 32'h0));

    // R10: a zero status write restores every queue at the next edge
    assert_soft_clear_R10: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == 6'h14 && be == BE_BYTE0 && wdata[7:0] == 8'h0)
        |=> (q_enable == '0 && q_size == QMAX_TABLE));

    // R6: per-queue offsets read zero while the selection is out of range
    assert_oor_read_R6: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !q_ok && addr[5:2] >= 4'd6 && addr[5:2] <= 4'd13) |=> (rd_data == 32'h0));

    // R9: misaligned reads return zero
    assert_misaligned_read_R9: assert property (@(posedge clk) disable iff (rst)
        (rd_en && addr[1:0] != 2'b00) |=> (rd_data == 32'h0));

    // R4: the queue count is constant at its natural offset
    assert_count_ro_R4: assert property (@(posedge clk) disable iff (rst)
        (rd_en && addr == 6'h10 && be == BE_HALF1) |=> (rd_data == {QCOUNT, 16'h0}));

endmodule

// File: tb/vq_common_cfg_test.sv
module vq_common_cfg_test;
    localparam int CLK_PERIOD = 10;
    localparam int NQ = 4;

    logic          clk = 1'b0;
    logic          rst, wr_en, rd_en;
    logic [5:0]    addr;
    logic [3:0]    be;
    logic [31:0]   wdata, rd_data;
    logic [NQ-1:0] q_enable;
    logic [NQ*16-1:0] q_size;

    int n_cmp = 0;
    int n_bad = 0;

    logic [15:0] exp_size [NQ];
    logic        exp_en   [NQ];
    logic [31:0] exp_desc_lo [NQ];
    logic [15:0] exp_msix;

    always #(CLK_PERIOD/2) clk = ~clk;

    vq_common_cfg uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .be(be),
        .wdata(wdata), .rd_data(rd_data), .q_enable(q_enable), .q_size(q_size)
    );

    function automatic logic [15:0] max_of(input int q);
        return 16'(256 >> q);
    endfunction

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic do_wr(input logic [5:0] a, input logic [3:0] b, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; be = b; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_rd(input logic [5:0] a, input logic [3:0] b, output logic [31:0] d);
        @(negedge clk);
        rd_en = 1'b1; addr = a; be = b;
        @(negedge clk);
        rd_en = 1'b0;
        d = rd_data;
    endtask

    task automatic rd_chk(input string tag, input logic [5:0] a, input logic [3:0] b,
                          input logic [31:0] exp);
        logic [31:0] v;
        do_rd(a, b, v);
        chk(tag, v, exp);
    endtask

    task automatic pick_q(input logic [15:0] q);
        do_wr(6'h14, 4'hC, {q, 16'h0});
    endtask

    task automatic model_reset();
        for (int q = 0; q < NQ; q++) begin
            exp_size[q] = max_of(q);
            exp_en[q] = 1'b0;
            exp_desc_lo[q] = 32'h0;
        end
        exp_msix = 16'hFFFF;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] v;
        rst = 1'b1; wr_en = 1'b0; rd_en = 1'b0; addr = '0; be = '0; wdata = '0;
        model_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset values
        rd_chk("R1 dev_sel",   6'h00, 4'hF, 32'h0);
        rd_chk("R1 drv_sel",   6'h08, 4'hF, 32'h0);
        rd_chk("R1 drv_feat",  6'h0C, 4'hF, 32'h0);
        rd_chk("R1 msix",      6'h10, 4'h3, 32'h0000_FFFF);
        rd_chk("R1 status",    6'h14, 4'h1, 32'h0);
        rd_chk("R1 qsel",      6'h14, 4'hC, 32'h0);
        rd_chk("R1 qvec",      6'h18, 4'hC, 32'hFFFF_0000);
        rd_chk("R1 qen",       6'h1C, 4'h3, 32'h0);
        for (int a = 8; a < 14; a++) rd_chk("R1 ring", 6'(a*4), 4'hF, 32'h0);
        for (int q = 0; q < NQ; q++) begin
            pick_q(16'(q));
            rd_chk("R1 qsize", 6'h18, 4'h3, {16'h0, max_of(q)});
        end
        chk("R1 q_size out", q_size[31:0], 32'h0080_0100);
        chk("R1 q_enable out", 32'(q_enable), 32'h0);

        // R2 device feature window
        rd_chk("R2 sel0", 6'h04, 4'hF, 32'h0000_0021);
        do_wr(6'h00, 4'hF, 32'd1);
        rd_chk("R2 sel1", 6'h04, 4'hF, 32'h0000_0009);
        rd_chk("R2 sel readback", 6'h00, 4'hF, 32'd1);
        do_wr(6'h00, 4'hF, 32'd2);
        rd_chk("R2 sel2", 6'h04, 4'hF, 32'h0);
        do_wr(6'h00, 4'hF, 32'hFFFF_FFFF);
        rd_chk("R2 selmax", 6'h04, 4'hF, 32'h0);

        // R3 driver feature window
        do_wr(6'h0C, 4'hF, 32'hA5A5_0001);
        do_wr(6'h08, 4'hF, 32'd1);
        do_wr(6'h0C, 4'hF, 32'h0000_0001);
        do_wr(6'h08, 4'hF, 32'd5);
        do_wr(6'h0C, 4'hF, 32'hDEAD_BEEF);
        rd_chk("R3 sel5 read", 6'h0C, 4'hF, 32'h0);
        do_wr(6'h08, 4'hF, 32'd0);
        rd_chk("R3 low half", 6'h0C, 4'hF, 32'hA5A5_0001);
        do_wr(6'h08, 4'hF, 32'd1);
        rd_chk("R3 high half", 6'h0C, 4'hF, 32'h0000_0001);

        // R4 read-only fields
        do_wr(6'h10, 4'hC, 32'hABCD_0000);
        rd_chk("R4 num_queues", 6'h10, 4'hC, 32'h0004_0000);
        do_wr(6'h00, 4'hF, 32'd0);
        do_wr(6'h04, 4'hF, 32'h1234_5678);
        rd_chk("R4 dev feat ro", 6'h04, 4'hF, 32'h0000_0021);
        for (int q = 0; q < NQ; q++) begin
            pick_q(16'(q));
            do_wr(6'h1C, 4'hC, 32'h7777_0000);
            rd_chk("R4 notify", 6'h1C, 4'hC, {16'(q), 16'h0});
        end

        // R5 banking of per-queue fields
        for (int q = 0; q < NQ; q++) begin
            pick_q(16'(q));
            do_wr(6'h18, 4'hC, {16'h0100 + 16'(q), 16'h0});
            do_wr(6'h1C, 4'h3, 32'(q & 1));
            exp_en[q] = 1'(q & 1);
            for (int h = 0; h < 6; h++)
                do_wr(6'(32 + h*4), 4'hF, 32'h1000_0000 * (h + 1) + 32'(q));
            exp_desc_lo[q] = 32'h1000_0000 + 32'(q);
        end
        chk("R8 q_enable out", 32'(q_enable), 32'hA);
        for (int q = NQ - 1; q >= 0; q--) begin
            pick_q(16'(q));
            rd_chk("R5 qvec", 6'h18, 4'hC, {16'h0100 + 16'(q), 16'h0});
            rd_chk("R5 qen", 6'h1C, 4'h3, 32'(q & 1));
            for (int h = 0; h < 6; h++)
                rd_chk("R5 ring half", 6'(32 + h*4), 4'hF, 32'h1000_0000 * (h + 1) + 32'(q));
        end

        // R7 / R8 size sweep
        for (int q = 0; q < NQ; q++) begin
            pick_q(16'(q));
            for (int s = 0; s <= 300; s++) begin
                logic [15:0] sv;
                sv = 16'(s);
                do_wr(6'h18, 4'h3, {16'h0, sv});
                if (sv == 0 || (((sv & (sv - 16'd1)) == 0) && sv <= max_of(q)))
                    exp_size[q] = sv;
                chk("R8 q_size slice", {16'h0, q_size[q*16 +: 16]}, {16'h0, exp_size[q]});
                rd_chk("R7 qsize", 6'h18, 4'h3, {16'h0, exp_size[q]});
            end
            do_wr(6'h18, 4'h3, 32'h0000_8000);
            rd_chk("R7 large pow2", 6'h18, 4'h3, {16'h0, exp_size[q]});
            do_wr(6'h18, 4'h3, {16'h0, max_of(q)});
            exp_size[q] = max_of(q);
            rd_chk("R7 at max", 6'h18, 4'h3, {16'h0, exp_size[q]});
        end

        // R6 out-of-range queue select
        for (int k = 0; k < 2; k++) begin
            pick_q(k == 0 ? 16'd4 : 16'd9);
            rd_chk("R6 qsize", 6'h18, 4'h3, 32'h0);
            rd_chk("R6 qvec", 6'h18, 4'hC, 32'h0);
            rd_chk("R6 qen", 6'h1C, 4'h3, 32'h0);
            rd_chk("R6 notify", 6'h1C, 4'hC, 32'h0);
            rd_chk("R6 desc", 6'h20, 4'hF, 32'h0);
            do_wr(6'h18, 4'h3, 32'd1);
            do_wr(6'h1C, 4'h3, 32'd1);
            do_wr(6'h20, 4'hF, 32'hFFFF_FFFF);
        end
        chk("R6 q_enable out", 32'(q_enable), 32'hA);
        for (int q = 0; q < NQ; q++) begin
            pick_q(16'(q));
            rd_chk("R6 bank size kept", 6'h18, 4'h3, {16'h0, exp_size[q]});
            rd_chk("R6 bank desc kept", 6'h20, 4'hF, exp_desc_lo[q]);
        end

        // R9 natural width rules
        for (int b = 0; b < 16; b++) begin
            do_wr(6'h10, 4'(b), 32'h5A5A_0000 | 32'(b));
            if (b == 3) exp_msix = 16'(b);
            rd_chk("R9 msix be sweep", 6'h10, 4'h3, {16'h0, exp_msix});
        end
        do_wr(6'h14, 4'h1, 32'h0000_003C);
        pick_q(16'd2);
        for (int b = 0; b < 16; b++) begin
            logic [31:0] e;
            e = (b == 1) ? 32'h3C : (b == 12) ? 32'h0002_0000 : 32'h0;
            rd_chk("R9 stat/qsel be sweep", 6'h14, 4'(b), e);
        end
        do_wr(6'h14, 4'h2, 32'h0000_FF00);
        rd_chk("R9 unused byte read", 6'h14, 4'h2, 32'h0);
        rd_chk("R9 status after unused write", 6'h14, 4'h1, 32'h3C);
        do_wr(6'h11, 4'h3, 32'h0000_1111);
        rd_chk("R9 misaligned write", 6'h10, 4'h3, {16'h0, exp_msix});
        rd_chk("R9 misaligned read", 6'h12, 4'hF, 32'h0);
        do_wr(6'h1C, 4'h1, 32'h0000_0001);
        rd_chk("R9 qen byte write dropped", 6'h1C, 4'h3, 32'(exp_en[2]));

        // R12 spare offsets
        rd_chk("R12 0x38", 6'h38, 4'hF, 32'h0);
        rd_chk("R12 0x3C", 6'h3C, 4'hF, 32'h0);

        // R11 read data returns to zero
        do_rd(6'h10, 4'h3, v);
        chk("R11 read value", v, {16'h0, exp_msix});
        @(negedge clk);
        chk("R11 idle zero", rd_data, 32'h0);

        // R10 soft reset through status
        do_wr(6'h08, 4'hF, 32'd0);
        do_wr(6'h14, 4'h1, 32'h0);
        model_reset();
        chk("R10 q_size out", q_size[31:0], 32'h0080_0100);
        chk("R10 q_size out hi", q_size[63:32], 32'h0020_0040);
        chk("R10 q_enable out", 32'(q_enable), 32'h0);
        rd_chk("R10 qsel", 6'h14, 4'hC, 32'h0);
        rd_chk("R10 status", 6'h14, 4'h1, 32'h0);
        rd_chk("R10 msix", 6'h10, 4'h3, 32'h0000_FFFF);
        rd_chk("R10 drv feat", 6'h0C, 4'hF, 32'h0);
        rd_chk("R10 qsize q0", 6'h18, 4'h3, 32'h0000_0100);
        rd_chk("R10 qvec q0", 6'h18, 4'hC, 32'hFFFF_0000);
        rd_chk("R10 desc q0", 6'h20, 4'hF, 32'h0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule